// File: doc/BRIEF.md
# Interrupt Recognition Unit

This unit decides which pending request a processor core services next, and at which point it does so. It takes nine request sources. Four of them are edge-triggered and are captured into pending latches. Four are level-sensitive and are looked at only while they are held. The last is a debug breakpoint request. The core supplies an instruction-boundary strobe, and selection happens only on that strobe. When several requests are eligible at one boundary, a fixed priority picks exactly one. The result goes out as a one-hot take vector together with an acknowledge pulse.

The unit also holds three pieces of state that gate recognition. The interrupt-enable flag qualifies the maskable interrupt. A software interrupt through a gate that clears this flag drops it, and software can set it again. A non-maskable-interrupt blocked state starts when an NMI is taken and ends on the core's handler-return strobe. A resume flag suppresses the debug breakpoint at the next boundary only and then clears itself. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `intr_recog`

## Requirements
- R1: After reset, `take` is all zero, `ack` is 0, `if_flag` is 0 and `rf_flag` is 0, and no edge request is pending.
- R2: A request is taken only in a cycle where `insn_bnd` is 1. The result shows on `take` (one-hot) and on `ack` in the following cycle, for one cycle. When no `insn_bnd` is given, `take` stays zero.
- R3: Fixed priority, highest first, with bit positions of `take`: bus error (0), probe run/stop (1), cache invalidate (2), management (3), re-init (4), NMI (5), debug breakpoint (6), maskable interrupt (7), clock stop (8).
- R4: A rising edge on `inval_req`, `mgmt_req`, `reinit_req` or `nmi_req` is latched and stays pending until a boundary takes it. The latch is cleared at the same edge that raises the matching `take` bit.
- R5: `bus_err_req`, `probe_req`, `irq_req` and `clkstop_req` are not latched. A level dropped before a boundary is never taken.
- R6: After NMI is taken, no further NMI is taken until `iret_done` is pulsed. An NMI edge that arrives while blocked stays pending and is taken at the first boundary after `iret_done`.
- R7: `sw_int` with `sw_gate_clr_if` = 1 clears `if_flag` in the next cycle. `sw_int` with `sw_gate_clr_if` = 0 leaves `if_flag` unchanged.
- R8: `irq_req` is taken only while `if_flag` is 1, and `if_set` sets `if_flag` to 1.
- R9: `rf_set` sets `rf_flag`. At the next boundary, the debug breakpoint is not taken and `rf_flag` clears. At the boundary after that, a held breakpoint request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_err_req | input | 1 | Bus error check request, level |
| probe_req | input | 1 | Probe run/stop request, level |
| inval_req | input | 1 | Cache invalidate request, edge |
| mgmt_req | input | 1 | Management-mode request, edge |
| reinit_req | input | 1 | Re-initialise request, edge |
| nmi_req | input | 1 | Non-maskable interrupt, edge |
| brk_req | input | 1 | Debug breakpoint request, level |
| irq_req | input | 1 | Maskable interrupt, level |
| clkstop_req | input | 1 | Clock stop request, level |
| insn_bnd | input | 1 | Instruction boundary strobe |
| iret_done | input | 1 | NMI handler return strobe |
| sw_int | input | 1 | Software interrupt dispatched |
| sw_gate_clr_if | input | 1 | Gate of that software interrupt clears IF |
| if_set | input | 1 | Software sets the interrupt-enable flag |
| rf_set | input | 1 | Software sets the resume flag |
| take | output | 9 | One-hot selected request |
| ack | output | 1 | Acknowledge pulse with take |
| if_flag | output | 1 | Interrupt-enable flag |
| rf_flag | output | 1 | Resume flag |

## Verification
Each selection is registered once. A boundary strobe sampled at one clock edge produces `take` and `ack` right after that edge, and they are held for that single cycle. Flag updates from `sw_int`, `if_set`, `rf_set` and `iret_done` are also visible one edge after the strobe. An edge request that rises in the same cycle as a boundary can be taken at that boundary. The bench drives every stimulus on a falling edge and reads the results on the next falling edge, so each check looks exactly one register stage after its cause. The reset state is read three cycles after release, which leaves room for the synchronizer.

// File: rtl/intr_recog_pkg.sv
package intr_recog_pkg;
  localparam int NSRC  = 9;
  localparam int NEDGE = 4;
  localparam int EDGE_BASE = 2;

  localparam int IDX_BUSERR  = 0;
  localparam int IDX_PROBE   = 1;
  localparam int IDX_INVAL   = 2;
  localparam int IDX_MGMT    = 3;
  localparam int IDX_REINIT  = 4;
  localparam int IDX_NMI     = 5;
  localparam int IDX_BRK     = 6;
  localparam int IDX_IRQ     = 7;
  localparam int IDX_CLKSTOP = 8;

  localparam int NMI_EDGE_POS = IDX_NMI - EDGE_BASE;
endpackage

// File: rtl/ir_rst_sync.sv
module ir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ir_edge_latch.sv
module ir_edge_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q, prev_d;
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] rise;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      rise[g]   = req_in[g] & ~prev_q[g];
      pend[g]   = pend_q[g] | rise[g];
      pend_d[g] = pend[g] & ~clr[g];
      prev_d[g] = req_in[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/ir_prio_pick.sv
module ir_prio_pick #(
  parameter int N = 9
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] sel
);
  logic found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ir_flags.sv
module ir_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic bnd,
  input  logic clr_if,
  input  logic set_if,
  input  logic set_rf,
  input  logic nmi_taken,
  input  logic nmi_ret,
  output logic if_q,
  output logic rf_q,
  output logic nmi_blk_q
);
  logic if_d, rf_d, blk_d;
  logic if_en, rf_en, blk_en;

  always_comb begin
    if_en  = clr_if | set_if;
    if_d   = ~clr_if;
    rf_en  = set_rf | bnd;
    rf_d   = set_rf;
    blk_en = nmi_taken | nmi_ret;
    blk_d  = nmi_taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_q      <= 1'b0;
      rf_q      <= 1'b0;
      nmi_blk_q <= 1'b0;
    end else begin
      if (if_en)  if_q      <= if_d;
      if (rf_en)  rf_q      <= rf_d;
      if (blk_en) nmi_blk_q <= blk_d;
    end
  end
endmodule

// File: rtl/intr_recog.sv
module intr_recog
  import intr_recog_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_err_req,
  input  logic            probe_req,
  input  logic            inval_req,
  input  logic            mgmt_req,
  input  logic            reinit_req,
  input  logic            nmi_req,
  input  logic            brk_req,
  input  logic            irq_req,
  input  logic            clkstop_req,
  input  logic            insn_bnd,
  input  logic            iret_done,
  input  logic            sw_int,
  input  logic            sw_gate_clr_if,
  input  logic            if_set,
  input  logic            rf_set,
  output logic [NSRC-1:0] take,
  output logic            ack,
  output logic            if_flag,
  output logic            rf_flag
);
  logic             rst_sync_n;
  logic [NEDGE-1:0] edge_in, edge_pend, edge_clr, edge_mask;
  logic [NSRC-1:0]  cand, pick, sel;
  logic [NSRC-1:0]  take_q, take_d;
  logic             ack_q, ack_d;
  logic             if_q, rf_q, nmi_blk_q;

  ir_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign edge_in = {nmi_req, reinit_req, mgmt_req, inval_req};

  ir_edge_latch #(.N(NEDGE)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .req_in (edge_in),
    .clr    (edge_clr),
    .pend   (edge_pend)
  );

  for (genvar g = 0; g < NEDGE; g++) begin : g_mask
    if (g == NMI_EDGE_POS) begin : g_nmi
      assign edge_mask[g] = ~nmi_blk_q;
    end else begin : g_other
      assign edge_mask[g] = 1'b1;
    end
  end

  always_comb begin
    cand                                 = '0;
    cand[IDX_BUSERR]                     = bus_err_req;
    cand[IDX_PROBE]                      = probe_req;
    cand[EDGE_BASE +: NEDGE]             = edge_pend & edge_mask;
    cand[IDX_BRK]                        = brk_req & ~rf_q;
    cand[IDX_IRQ]                        = irq_req & if_q;
    cand[IDX_CLKSTOP]                    = clkstop_req;
  end

  ir_prio_pick #(.N(NSRC)) u_pick (
    .cand (cand),
    .sel  (pick)
  );

  always_comb begin
    sel      = insn_bnd ? pick : '0;
    edge_clr = sel[EDGE_BASE +: NEDGE];
    take_d   = sel;
    ack_d    = |sel;
  end

  ir_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bnd       (insn_bnd),
    .clr_if    (sw_int & sw_gate_clr_if),
    .set_if    (if_set),
    .set_rf    (rf_set),
    .nmi_taken (sel[IDX_NMI]),
    .nmi_ret   (iret_done),
    .if_q      (if_q),
    .rf_q      (rf_q),
    .nmi_blk_q (nmi_blk_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      take_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      take_q <= take_d;
      ack_q  <= ack_d;
    end
  end

  assign take    = take_q;
  assign ack     = ack_q;
  assign if_flag = if_q;
  assign rf_flag = rf_q;
endmodule

// File: rtl/intr_recog_chk.sv
module intr_recog_chk
  import intr_recog_pkg::*;
(
  input logic            clk,
  input logic            rst_sync_n,
  input logic            insn_bnd,
  input logic            iret_done,
  input logic            sw_int,
  input logic            sw_gate_clr_if,
  input logic            rf_set,
  input logic [NSRC-1:0] take,
  input logic            ack,
  input logic            if_flag,
  input logic            rf_flag
);
  // R2
  onehot_take_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(take));
  // R2
  take_at_bnd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take != '0) |-> $past(insn_bnd));
  // R2
  ack_take_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack == (take != '0));
  // R6
  nmi_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take[IDX_NMI] && !iret_done) |=> !take[IDX_NMI]);
  // R8
  irq_if_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take[IDX_IRQ] |-> $past(if_flag));
  // R7
  if_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sw_int && sw_gate_clr_if) |=> !if_flag);
  // R9
  rf_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rf_flag && insn_bnd && !rf_set) |=> !rf_flag);
  // R9
  rf_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rf_flag && insn_bnd) |=> !take[IDX_BRK]);
endmodule

bind intr_recog intr_recog_chk u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .insn_bnd       (insn_bnd),
  .iret_done      (iret_done),
  .sw_int         (sw_int),
  .sw_gate_clr_if (sw_gate_clr_if),
  .rf_set         (rf_set),
  .take           (take),
  .ack            (ack),
  .if_flag        (if_flag),
  .rf_flag        (rf_flag)
);

// File: tb/intr_recog_test.sv
`timescale 1ns/1ps
module intr_recog_test;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_err_req, probe_req, inval_req, mgmt_req, reinit_req, nmi_req;
  logic brk_req, irq_req, clkstop_req, insn_bnd, iret_done;
  logic sw_int, sw_gate_clr_if, if_set, rf_set;
  logic [8:0] take;
  logic ack, if_flag, rf_flag;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  intr_recog uut (
    .clk(clk), .rst_n(rst_n),
    .bus_err_req(bus_err_req), .probe_req(probe_req), .inval_req(inval_req),
    .mgmt_req(mgmt_req), .reinit_req(reinit_req), .nmi_req(nmi_req),
    .brk_req(brk_req), .irq_req(irq_req), .clkstop_req(clkstop_req),
    .insn_bnd(insn_bnd), .iret_done(iret_done), .sw_int(sw_int),
    .sw_gate_clr_if(sw_gate_clr_if), .if_set(if_set), .rf_set(rf_set),
    .take(take), .ack(ack), .if_flag(if_flag), .rf_flag(rf_flag)
  );

  function automatic logic [8:0] bit1(input int i);
    return 9'(1) << i;
  endfunction

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_take(input string tag, input logic [8:0] exp);
    n_chk++;
    if (take !== exp || ack !== (exp != 9'd0)) begin
      n_bad++;
      $display("FAIL %s: take=%b ack=%b expected take=%b ack=%b",
               tag, take, ack, exp, exp != 9'd0);
    end
  endtask

  task automatic boundary(input string tag, input logic [8:0] exp);
    insn_bnd = 1'b1;
    @(negedge clk);
    insn_bnd = 1'b0;
    chk_take(tag, exp);
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    {bus_err_req, probe_req, inval_req, mgmt_req, reinit_req, nmi_req} = '0;
    {brk_req, irq_req, clkstop_req, insn_bnd, iret_done} = '0;
    {sw_int, sw_gate_clr_if, if_set, rf_set} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_take("R1 reset take/ack", 9'd0);
    chk_bit("R1 reset if_flag", if_flag, 1'b0);
    chk_bit("R1 reset rf_flag", rf_flag, 1'b0);
    boundary("R1 no pending after reset", 9'd0);
  endtask

  task automatic t_priority();
    pulse(inval_req); pulse(mgmt_req); pulse(reinit_req); pulse(nmi_req);
    bus_err_req = 1'b1; probe_req = 1'b1;
    @(negedge clk);
    boundary("R3 bus error first", bit1(0));
    bus_err_req = 1'b0;
    boundary("R3 probe second", bit1(1));
    probe_req = 1'b0;
    boundary("R3 R4 invalidate", bit1(2));
    boundary("R3 R4 management", bit1(3));
    boundary("R3 R4 re-init", bit1(4));
    boundary("R3 R4 nmi", bit1(5));
    boundary("R4 latches emptied", 9'd0);
    pulse(iret_done);
  endtask

  task automatic t_no_bnd();
    pulse(nmi_req);
    for (int i = 0; i < 5; i++) chk_take("R2 nothing without boundary", 9'd0);
    boundary("R2 R4 pending nmi on boundary", bit1(5));
    pulse(iret_done);
  endtask

  task automatic t_nmi_block();
    pulse(nmi_req);
    boundary("R6 first nmi", bit1(5));
    pulse(nmi_req);
    boundary("R6 blocked nmi", 9'd0);
    boundary("R6 still blocked", 9'd0);
    pulse(iret_done);
    boundary("R6 nmi after return", bit1(5));
    pulse(iret_done);
  endtask

  task automatic t_if();
    irq_req = 1'b1;
    @(negedge clk);
    boundary("R8 irq masked with IF=0", 9'd0);
    pulse(if_set);
    chk_bit("R8 if_set", if_flag, 1'b1);
    boundary("R8 irq taken", bit1(7));
    sw_int = 1'b1; sw_gate_clr_if = 1'b0;
    @(negedge clk);
    sw_int = 1'b0;
    chk_bit("R7 gate keeps IF", if_flag, 1'b1);
    sw_int = 1'b1; sw_gate_clr_if = 1'b1;
    @(negedge clk);
    sw_int = 1'b0; sw_gate_clr_if = 1'b0;
    chk_bit("R7 gate clears IF", if_flag, 1'b0);
    boundary("R7 irq blocked after clear", 9'd0);
    pulse(if_set);
    irq_req = 1'b0; clkstop_req = 1'b1;
    boundary("R3 R8 clock stop lowest", bit1(8));
    irq_req = 1'b1;
    boundary("R3 irq over clock stop", bit1(7));
    irq_req = 1'b0; clkstop_req = 1'b0;
  endtask

  task automatic t_level_lost();
    pulse(irq_req);
    pulse(bus_err_req);
    pulse(clkstop_req);
    boundary("R5 dropped levels lost", 9'd0);
  endtask

  task automatic t_resume();
    brk_req = 1'b1; irq_req = 1'b1;
    pulse(rf_set);
    chk_bit("R9 rf set", rf_flag, 1'b1);
    boundary("R9 breakpoint suppressed", bit1(7));
    chk_bit("R9 rf self-clear", rf_flag, 1'b0);
    boundary("R9 R3 breakpoint over irq", bit1(6));
    brk_req = 1'b0; irq_req = 1'b0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_priority();
    t_no_bnd();
    t_nmi_block();
    t_if();
    t_level_lost();
    t_resume();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule